// File: doc/BRIEF.md
# Repeated-Block Entropy Health Check

This block guards the raw byte stream of a hardware noise source before that stream is used to seed a deterministic generator. Bytes arrive over a valid/ready handshake and are grouped into blocks of 72 bytes, which is 576 bits. Each new block is compared with the block that came just before it. If the two blocks match in every bit, the source is treated as stuck. A sticky failure is then raised and the offending block is dropped.

The first block received after reset or after a clear has nothing to be compared with. It is therefore kept only as the reference and is never released. Every later block is held in local storage while it is compared byte by byte against the stored reference. A running mismatch flag is judged on the final byte. A block that differs from its reference is sent downstream in arrival order and then becomes the new reference. While a failure holds, the block accepts no input and produces no output. Only the clear input brings it back, and after a clear it starts again by capturing a fresh reference block.

Top module: `rng_repeat_guard`

## Requirements
- R1: After reset, `fail` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: The first 72-byte block accepted after reset or after a clear produces no output bytes and does not raise `fail`.
- R3: A block that differs from the preceding block in at least one bit is sent on the output as exactly 72 bytes, in arrival order. No byte of it appears before its last input byte has been accepted.
- R4: A block that is bit-for-bit identical to the preceding block sets `fail` to 1 in the cycle after its last byte is accepted, and none of its bytes is sent on the output.
- R5: Once `fail` is 1, it stays 1 and `in_ready` stays 0 until `clr` is asserted, whatever happens on `in_valid`.
- R6: A one-cycle `clr` drives `fail` to 0 and `in_ready` to 1 on the next cycle. The next block is then taken as a new reference only, even if it equals the block seen before the clear.
- R7: While a passed block is being sent, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.
- R8: A block that has passed replaces the reference, so the next block is compared with it and not with any older block.
- R9: A difference confined to a single byte, at any of the 72 positions, counts as a mismatch.
- R10: `out_valid` is never 1 while `fail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Clears a failure and restarts reference capture |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Raw entropy byte |
| in_ready | output | 1 | Block can accept an input byte |
| out_valid | output | 1 | Output byte valid (registered) |
| out_data | output | 8 | Approved entropy byte (registered) |
| out_ready | input | 1 | Downstream accepts the output byte |
| fail | output | 1 | Sticky repeated-block failure (registered) |

## Verification
The inline assertions check the following on every cycle:
- a failure is sticky and blocks all input and output;
- `clr` releases the failure;
- the input and output handshakes never run at the same time;
- a stalled output byte holds steady.

Other behaviour can only be shown by the bench's scenarios:
- which blocks are forwarded;
- the exact byte order of a forwarded block;
- that a single flipped byte at each of the 72 positions is detected;
- that a passed block becomes the new reference.

The bench also shows that the first block after a clear is only captured, and that a stuck block is detected and never forwarded.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    ST_SEED  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HALT  = 2'd3
  } rb_state_e;
endpackage

// File: rtl/rb_store.sv
// Two-bank block store: one write port, two asynchronous read ports.
module rb_store #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int W         = 8,
  parameter int BLK_BYTES = 72,
  parameter int IW        = $clog2(BLK_BYTES),
  parameter int AW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] cmp_addr,
  input  logic [W-1:0]  cmp_byte,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_byte,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic          fail
);
  localparam logic [IW-1:0] LAST = IW'(BLK_BYTES - 1);

  rb_state_e     state_q;
  logic          bank_q;     // bank holding the reference block
  logic [IW-1:0] idx_q;      // write position within incoming block
  logic [IW-1:0] rd_idx_q;   // read position during drain
  logic          rd_done_q;
  logic          diff_q;     // running mismatch flag
  logic          accept, last_in, blk_diff, load;

  assign in_ready = (state_q == ST_SEED) || (state_q == ST_CHECK);
  assign accept   = in_valid && in_ready;
  assign last_in  = (idx_q == LAST);
  assign blk_diff = diff_q || (in_data != cmp_byte);
  assign load     = !out_valid || out_ready;

  assign wr_en    = accept;
  assign wr_addr  = {~bank_q, idx_q};
  assign cmp_addr = {bank_q, idx_q};
  assign rd_addr  = {bank_q, rd_idx_q};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q   <= ST_SEED;
      bank_q    <= 1'b0;
      idx_q     <= '0;
      rd_idx_q  <= '0;
      rd_done_q <= 1'b0;
      diff_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      fail      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SEED: if (accept) begin
          idx_q <= last_in ? '0 : idx_q + 1'b1;
          if (last_in) begin
            bank_q  <= ~bank_q;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: if (accept) begin
          idx_q  <= last_in ? '0 : idx_q + 1'b1;
          diff_q <= last_in ? 1'b0 : blk_diff;
          if (last_in) begin
            if (blk_diff) begin
              bank_q    <= ~bank_q;
              rd_idx_q  <= '0;
              rd_done_q <= 1'b0;
              state_q   <= ST_DRAIN;
            end else begin
              fail    <= 1'b1;
              state_q <= ST_HALT;
            end
          end
        end
        ST_DRAIN: if (load) begin
          if (!rd_done_q) begin
            out_valid <= 1'b1;
            out_data  <= rd_byte;
            if (rd_idx_q == LAST) rd_done_q <= 1'b1;
            else                  rd_idx_q  <= rd_idx_q + 1'b1;
          end else begin
            out_valid <= 1'b0;
            state_q   <= ST_CHECK;
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fail && !clr |=> fail);
  // R5
  fail_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> !in_ready);
  // R10
  fail_no_output_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> !out_valid);
  // R6
  clr_release_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !fail && in_ready && !out_valid);
  // R7
  drain_no_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !clr |=> out_valid && $stable(out_data));
endmodule

// File: rtl/rng_repeat_guard.sv
module rng_repeat_guard #(
  parameter int W         = 8,
  parameter int BLK_BYTES = 72
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         fail
);
  localparam int IW = $clog2(BLK_BYTES);
  localparam int AW = IW + 1;

  logic          wr_en;
  logic [AW-1:0] wr_addr, cmp_addr, rd_addr;
  logic [W-1:0]  cmp_byte, rd_byte;

  rb_store #(.W(W), .AW(AW)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (in_data),
    .raddr_a (cmp_addr),
    .rdata_a (cmp_byte),
    .raddr_b (rd_addr),
    .rdata_b (rd_byte)
  );

  rb_ctrl #(.W(W), .BLK_BYTES(BLK_BYTES), .IW(IW), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cmp_addr  (cmp_addr),
    .cmp_byte  (cmp_byte),
    .rd_addr   (rd_addr),
    .rd_byte   (rd_byte),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .fail      (fail)
  );
endmodule

// File: tb/sim_rng_repeat_guard.sv
`timescale 1ns/1ps
module sim_rng_repeat_guard;
  localparam int N = 72;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       fail;

  int checks = 0;
  int failures = 0;
  int out_count = 0;
  int exp_count = 0;
  bit done = 1'b0;
  logic [7:0] blk [N];

  always #5 clk = ~clk;

  rng_repeat_guard u0 (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .fail(fail)
  );

  always @(posedge clk) if (!rst && out_valid && out_ready) out_count++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < N; i++) blk[i] = 8'((seed * 29) + (i * 7) + (i >> 2));
  endtask

  task automatic send_block();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = blk[i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input string tag);
    bit ok = 1'b1;
    check(!in_ready, "R7 in_ready low in drain", int'(in_ready), 0);
    for (int i = 0; i < N; i++) begin
      if (i % 3 == 1) begin
        logic [7:0] d;
        logic v;
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        d = out_data; v = out_valid;
        @(negedge clk);
        if (!(out_valid === v && out_data === d)) begin
          check(1'b0, "R7 hold under stall", int'(out_data), int'(d));
        end
      end
      out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      if (out_data !== blk[i]) begin
        ok = 1'b0;
        $display("FAIL %s byte %0d actual=%0d expected=%0d", tag, i, out_data, blk[i]);
      end
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
    end
    checks++;
    if (!ok) failures++;
    exp_count += N;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check(fail == 1'b0, "R1 fail after reset", int'(fail), 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R2: reference block only
    fill(1);
    send_block();
    repeat (4) @(negedge clk);
    check(!fail && !out_valid && in_ready, "R2 first block not forwarded", int'(out_valid), 0);

    // R3: differing block forwarded in order
    fill(2);
    send_block();
    check(!fail, "R3 no fail on differing block", int'(fail), 0);
    collect("R3 forward order");

    // R9: single-byte flip at every position
    for (int p = 0; p < N; p++) begin
      blk[p] = blk[p] ^ 8'h01;
      send_block();
      check(!fail, "R9 single byte diff not a failure", int'(fail), 0);
      collect("R9 forward single diff");
    end

    // R8: reference replaced by passing block
    fill(1); send_block(); collect("R8 A after sweep");
    fill(2); send_block(); collect("R8 B");
    fill(1); send_block();
    check(!fail, "R8 A vs B passes", int'(fail), 0);
    collect("R8 A again after B");

    // R4: identical block
    send_block();
    check(fail == 1'b1, "R4 repeat sets fail", int'(fail), 1);
    check(!out_valid, "R4 repeat not forwarded", int'(out_valid), 0);

    // R5 / R10: sticky, input refused
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!(fail && !in_ready && !out_valid))
        check(1'b0, "R5 sticky fail blocks io", int'(fail), 1);
    end
    in_valid = 1'b0;
    check(fail && !in_ready, "R5 still failed", int'(fail), 1);
    check(!out_valid, "R10 no output while failed", int'(out_valid), 0);

    // R6: clear
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(!fail && in_ready, "R6 clear releases", int'(fail), 0);
    send_block();
    repeat (4) @(negedge clk);
    check(!fail && !out_valid, "R6 post-clear block is reference only", int'(out_valid), 0);
    send_block();
    check(fail == 1'b1, "R4 repeat after clear-reference", int'(fail), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    fill(5); send_block();
    fill(6); send_block();
    check(!fail, "R6 new pair passes", int'(fail), 0);
    collect("R6 forward after clear");

    repeat (4) @(negedge clk);
    check(out_count == exp_count, "R3 total forwarded bytes", out_count, exp_count);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule